// File: doc/BRIEF.md
# Wormhole Flit Switch

This block is a multi-port crossbar for packets that travel as a chain of narrow flits. A packet opens with a head flit whose low data bits name the output port. The switch routes the head as soon as it arrives and does not wait for the rest of the packet. The head reserves its output for the input it came from. Body flits then follow that reservation, and the tail flit closes it. Each output holds one flit and nothing more. When a downstream stage stops taking flits, the stall reaches the sending input at once, and the packet stays spread across the stages upstream.

A flit is `{type[1:0], data[DATA_W-1:0]}`, packed flat per port into the flit buses. Port `k` uses bits `k*FLIT_W` upward. The type codes are head = 2'b01 and tail = 2'b11. Any other code is a body flit. Every port uses valid/ready flow control. A flit moves when valid and ready are both high at a rising clock edge.

Top module: `wh_switch`

## Requirements
- R1: While reset is held, and in the first cycle after it, every `out_valid` is low and every output is unreserved.
- R2: A head flit accepted on an input appears unchanged on the output named by its low `$clog2(PORTS)` data bits, starting in the next cycle.
- R3: Forwarding is cut-through. A head flit reaches the output while the later flits of its packet are still waiting upstream, so no more than one flit per output is ever stored.
- R4: After a head is accepted, the body and tail flits on that input follow the same output, whatever their data bits hold.
- R5: From the accepted head until its tail leaves the output, that output belongs to one input. A head from any other input that targets it sees `in_ready` low.
- R6: An output is released in the cycle after its buffered tail flit is taken downstream (`out_valid` and `out_ready` both high). It cannot be granted in the same cycle.
- R7: When several heads compete for a free output, the grant rotates round-robin. The search starts at the input after the last one granted that output, and input 0 has first turn after reset.
- R8: The `in_ready` of a reserved input equals, combinationally, "its output is empty or `out_ready` is high". An output that is stalled keeps its flit stable.
- R9: A non-head flit on an input with no reservation is taken (`in_ready` high) and discarded. It never appears on any output.
- R10: Packets headed to different outputs move at the same time, one flit per output per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | PORTS | Per-input flit valid |
| in_flit | input | PORTS*(DATA_W+2) | Per-input flit `{type, data}` |
| in_ready | output | PORTS | Per-input ready, combinational |
| out_valid | output | PORTS | Per-output flit valid |
| out_flit | output | PORTS*(DATA_W+2) | Per-output flit `{type, data}` |
| out_ready | input | PORTS | Per-output downstream ready |

## Verification
The bench drives several inputs with heads aimed at the same output. A fixed-priority or non-rotating arbiter would then serve inputs in the wrong order, and a missing lock would interleave flits from two packets on one output. The bench holds a tail flit on a stalled output while another head waits for that output. A release made too early would grant the waiting head in the same cycle the tail leaves, and a release made too late would add a dead cycle. The bench toggles the downstream ready at random. A buffer that overwrites would lose flits, and a registered ready would accept one flit too many. It also sends stray body flits on unreserved inputs, which a faulty design would leak onto an output or would leave hanging.

// File: rtl/wh_pkg.sv
package wh_pkg;
   localparam int TYPE_W = 2;
   localparam logic [TYPE_W-1:0] FT_HEAD = 2'b01;
   localparam logic [TYPE_W-1:0] FT_BODY = 2'b10;
   localparam logic [TYPE_W-1:0] FT_TAIL = 2'b11;

   function automatic logic type_is_head(input logic [TYPE_W-1:0] t);
      return t == FT_HEAD;
   endfunction

   function automatic logic type_is_tail(input logic [TYPE_W-1:0] t);
      return t == FT_TAIL;
   endfunction
endpackage

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   logic [IW-1:0] last_q;
   logic [IW-1:0] win_idx;

   if (N < 2) begin : g_bad_n
      $error("wh_rr_arb: N must be at least 2");
   end

   always_comb begin
      gnt     = '0;
      win_idx = last_q;
      for (int k = 1; k <= N; k++) begin
         int c;
         c = (int'(last_q) + k) % N;
         if (en && (gnt == '0) && req[c]) begin
            gnt[c]  = 1'b1;
            win_idx = IW'(c);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         last_q <= IW'(N - 1);
      else if (gnt != '0)
         last_q <= win_idx;
   end

   // R7
   onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && ((gnt & ~req) == '0));
endmodule

// File: rtl/wh_out_slot.sv
module wh_out_slot #(
   parameter int FLIT_W = 6,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [FLIT_W-1:0] wr_flit,
   input  logic [IDX_W-1:0]  wr_src,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [FLIT_W-1:0] out_flit,
   output logic              space,
   output logic              own_v,
   output logic [IDX_W-1:0]  own_idx,
   output logic              closing
);
   import wh_pkg::*;

   logic              bv_q;
   logic [FLIT_W-1:0] bf_q;
   logic              pop;
   logic              pop_tail;

   if (FLIT_W <= TYPE_W) begin : g_bad_w
      $error("wh_out_slot: flit must carry data bits");
   end

   assign pop       = bv_q && out_ready;
   assign pop_tail  = pop && type_is_tail(bf_q[FLIT_W-1 -: TYPE_W]);
   assign space     = !bv_q || out_ready;
   assign out_valid = bv_q;
   assign out_flit  = bf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bv_q    <= 1'b0;
         bf_q    <= '0;
         own_v   <= 1'b0;
         own_idx <= '0;
         closing <= 1'b0;
      end else begin
         if (pop_tail) begin
            own_v   <= 1'b0;
            closing <= 1'b0;
         end
         if (wr) begin
            bv_q <= 1'b1;
            bf_q <= wr_flit;
            if (type_is_head(wr_flit[FLIT_W-1 -: TYPE_W])) begin
               own_v   <= 1'b1;
               own_idx <= wr_src;
               closing <= 1'b0;
            end
            if (type_is_tail(wr_flit[FLIT_W-1 -: TYPE_W]))
               closing <= 1'b1;
         end else if (pop) begin
            bv_q <= 1'b0;
         end
      end
   end

   // R8
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (!bv_q || out_ready));

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bv_q && !out_ready) |=> (bv_q && $stable(bf_q)));

   // R5
   owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_v && !pop_tail) |=> (own_v && $stable(own_idx)));

   // R6
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_tail |=> !own_v);

   // R5
   closed_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      closing |-> !wr);
endmodule

// File: rtl/wh_switch.sv
module wh_switch #(
   parameter int PORTS  = 4,
   parameter int DATA_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PORTS-1:0]             in_valid,
   input  logic [PORTS*(DATA_W+2)-1:0]  in_flit,
   output logic [PORTS-1:0]             in_ready,
   output logic [PORTS-1:0]             out_valid,
   output logic [PORTS*(DATA_W+2)-1:0]  out_flit,
   input  logic [PORTS-1:0]             out_ready
);
   import wh_pkg::*;

   localparam int FLIT_W = DATA_W + TYPE_W;
   localparam int IDX_W  = (PORTS > 1) ? $clog2(PORTS) : 1;

   if (PORTS < 2) begin : g_bad_ports
      $error("wh_switch: PORTS must be at least 2");
   end
   if (DATA_W < IDX_W) begin : g_bad_data
      $error("wh_switch: DATA_W too narrow for the destination field");
   end

   logic [FLIT_W-1:0] iflit   [PORTS];
   logic [PORTS-1:0]  is_head;
   logic [PORTS-1:0]  bound;
   logic [IDX_W-1:0]  route   [PORTS];
   logic [PORTS-1:0]  req_o   [PORTS];
   logic [PORTS-1:0]  gnt_o   [PORTS];
   logic [PORTS-1:0]  head_gnt;
   logic [PORTS-1:0]  space;
   logic [PORTS-1:0]  own_v;
   logic [PORTS-1:0]  closing;
   logic [IDX_W-1:0]  own_idx [PORTS];
   logic [PORTS-1:0]  wr;
   logic [FLIT_W-1:0] wflit   [PORTS];
   logic [IDX_W-1:0]  wsrc    [PORTS];

   for (genvar g = 0; g < PORTS; g++) begin : g_unpack
      assign iflit[g]   = in_flit[g*FLIT_W +: FLIT_W];
      assign is_head[g] = type_is_head(iflit[g][FLIT_W-1 -: TYPE_W]);
   end

   // Which output (if any) each input currently holds open.
   always_comb begin
      for (int i = 0; i < PORTS; i++) begin
         bound[i] = 1'b0;
         route[i] = '0;
         for (int j = 0; j < PORTS; j++) begin
            if (own_v[j] && !closing[j] && own_idx[j] == IDX_W'(i)) begin
               bound[i] = 1'b1;
               route[i] = IDX_W'(j);
            end
         end
      end
   end

   // Head requests, sorted by destination.
   always_comb begin
      for (int j = 0; j < PORTS; j++)
         for (int i = 0; i < PORTS; i++)
            req_o[j][i] = in_valid[i] && !bound[i] && is_head[i] &&
                          (iflit[i][IDX_W-1:0] == IDX_W'(j));
   end

   for (genvar j = 0; j < PORTS; j++) begin : g_arb
      wh_rr_arb #(.N(PORTS)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (!own_v[j] && space[j]),
         .req   (req_o[j]),
         .gnt   (gnt_o[j])
      );
   end

   always_comb begin
      for (int i = 0; i < PORTS; i++) begin
         head_gnt[i] = 1'b0;
         for (int j = 0; j < PORTS; j++)
            head_gnt[i] = head_gnt[i] | gnt_o[j][i];
         if (bound[i])
            in_ready[i] = space[route[i]];
         else if (is_head[i])
            in_ready[i] = head_gnt[i];
         else
            in_ready[i] = 1'b1;
      end
   end

   // Crossbar: select the flit each output slot takes this cycle.
   always_comb begin
      for (int j = 0; j < PORTS; j++) begin
         wr[j]    = 1'b0;
         wflit[j] = '0;
         wsrc[j]  = '0;
         for (int i = 0; i < PORTS; i++) begin
            if (in_valid[i] && in_ready[i] &&
                ((bound[i] && route[i] == IDX_W'(j)) || gnt_o[j][i])) begin
               wr[j]    = 1'b1;
               wflit[j] = iflit[i];
               wsrc[j]  = IDX_W'(i);
            end
         end
      end
   end

   for (genvar j = 0; j < PORTS; j++) begin : g_slot
      wh_out_slot #(.FLIT_W(FLIT_W), .IDX_W(IDX_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr        (wr[j]),
         .wr_flit   (wflit[j]),
         .wr_src    (wsrc[j]),
         .out_ready (out_ready[j]),
         .out_valid (out_valid[j]),
         .out_flit  (out_flit[j*FLIT_W +: FLIT_W]),
         .space     (space[j]),
         .own_v     (own_v[j]),
         .own_idx   (own_idx[j]),
         .closing   (closing[j])
      );

      // R5
      grant_free_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (gnt_o[j] != '0) |-> !own_v[j]);
   end
endmodule

// File: tb/wh_switch_tb.sv
`timescale 1ns/1ps
module wh_switch_tb;
   localparam int P  = 4;
   localparam int DW = 4;
   localparam int FW = DW + 2;
   localparam int IW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [P-1:0]    in_valid = '0;
   logic [P*FW-1:0] in_flit = '0;
   logic [P-1:0]    in_ready;
   logic [P-1:0]    out_valid;
   logic [P*FW-1:0] out_flit;
   logic [P-1:0]    out_ready = '0;

   always #2.5 clk = ~clk;

   wh_switch #(.PORTS(P), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
      .in_ready(in_ready), .out_valid(out_valid), .out_flit(out_flit),
      .out_ready(out_ready));

   int vectors = 0;
   int miscompares = 0;
   string cur_req = "R1";

   // Reference model state
   int            m_bv[P], m_own[P], m_idx[P], m_cls[P], m_ptr[P];
   logic [FW-1:0] m_bf[P];
   // Stimulus generators
   int            g_left[P], g_act[P], g_dest[P], g_junk[P];
   logic [FW-1:0] g_flit[P];
   int            p_valid = 100, p_ready = 100, len_min = 2, len_max = 5;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] next_flit(input int left);
      logic [DW-1:0] d;
      d = DW'($urandom);
      return (left == 1) ? {2'b11, d} : {2'b10, d};
   endfunction

   task automatic step();
      int sp[P], bnd[P], rte[P], g[P], rdy[P];
      @(negedge clk);
      for (int j = 0; j < P; j++) begin
         chk(out_valid[j] == (m_bv[j] != 0), $sformatf("out_valid[%0d]", j), out_valid[j], m_bv[j]);
         if (m_bv[j] != 0)
            chk(out_flit[j*FW +: FW] == m_bf[j], $sformatf("out_flit[%0d]", j), out_flit[j*FW +: FW], m_bf[j]);
      end
      for (int i = 0; i < P; i++) begin
         if (g_left[i] == 0 && g_act[i] != 0 && ($urandom % 4) != 0) begin
            int d;
            logic [DW-1:0] dat;
            d = (g_dest[i] < 0) ? int'($urandom % P) : g_dest[i];
            dat = DW'($urandom);
            dat[IW-1:0] = IW'(d);
            g_left[i] = len_min + int'($urandom % (len_max - len_min + 1));
            g_flit[i] = {2'b01, dat};
         end
         if (g_left[i] > 0) begin
            in_valid[i] = (int'($urandom % 100) < p_valid);
            in_flit[i*FW +: FW] = g_flit[i];
         end else if (g_junk[i] != 0) begin
            in_valid[i] = 1'b1;
            in_flit[i*FW +: FW] = {2'b10, DW'($urandom)};
         end else begin
            in_valid[i] = 1'b0;
            in_flit[i*FW +: FW] = {2'b01, DW'($urandom)};
         end
      end
      for (int j = 0; j < P; j++) out_ready[j] = (int'($urandom % 100) < p_ready);
      #1;
      // Model: combinational view
      for (int j = 0; j < P; j++) sp[j] = (m_bv[j] == 0 || out_ready[j]) ? 1 : 0;
      for (int i = 0; i < P; i++) begin
         bnd[i] = 0; rte[i] = 0;
         for (int j = 0; j < P; j++)
            if (m_own[j] != 0 && m_cls[j] == 0 && m_idx[j] == i) begin bnd[i] = 1; rte[i] = j; end
      end
      for (int j = 0; j < P; j++) begin
         g[j] = -1;
         if (m_own[j] == 0 && sp[j] != 0)
            for (int k = 1; k <= P; k++) begin
               int c;
               c = (m_ptr[j] + k) % P;
               if (g[j] < 0 && in_valid[c] && bnd[c] == 0 &&
                   in_flit[c*FW+DW +: 2] == 2'b01 && int'(in_flit[c*FW +: IW]) == j)
                  g[j] = c;
            end
      end
      for (int i = 0; i < P; i++) begin
         if (bnd[i] != 0) rdy[i] = sp[rte[i]];
         else if (in_flit[i*FW+DW +: 2] == 2'b01) begin
            rdy[i] = 0;
            for (int j = 0; j < P; j++) if (g[j] == i) rdy[i] = 1;
         end else rdy[i] = 1;
         chk(in_ready[i] == (rdy[i] != 0), $sformatf("in_ready[%0d]", i), in_ready[i], rdy[i]);
      end
      // Model: next state
      for (int j = 0; j < P; j++) begin
         if (m_bv[j] != 0 && out_ready[j]) begin
            if (m_bf[j][FW-1 -: 2] == 2'b11) begin m_own[j] = 0; m_cls[j] = 0; end
            m_bv[j] = 0;
         end
         for (int i = 0; i < P; i++)
            if (in_valid[i] && rdy[i] != 0 && ((bnd[i] != 0 && rte[i] == j) || g[j] == i)) begin
               m_bv[j] = 1;
               m_bf[j] = in_flit[i*FW +: FW];
               if (m_bf[j][FW-1 -: 2] == 2'b01) begin m_own[j] = 1; m_idx[j] = i; m_cls[j] = 0; end
               if (m_bf[j][FW-1 -: 2] == 2'b11) m_cls[j] = 1;
            end
         if (g[j] >= 0) m_ptr[j] = g[j];
      end
      for (int i = 0; i < P; i++)
         if (in_valid[i] && rdy[i] != 0 && g_left[i] > 0) begin
            g_left[i]--;
            if (g_left[i] > 0) g_flit[i] = next_flit(g_left[i]);
         end
   endtask

   task automatic run(input int n);
      for (int c = 0; c < n; c++) step();
   endtask

   task automatic quiet();
      for (int i = 0; i < P; i++) begin g_act[i] = 0; g_junk[i] = 0; g_dest[i] = -1; end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int j = 0; j < P; j++) begin
         m_bv[j] = 0; m_own[j] = 0; m_idx[j] = 0; m_cls[j] = 0; m_ptr[j] = P - 1; m_bf[j] = '0;
         g_left[j] = 0; g_flit[j] = '0;
      end
      quiet();
      // R1: outputs idle under reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == '0, "out_valid in reset", out_valid, 0);
      @(posedge clk);
      rst_n = 1'b1;
      run(3);

      cur_req = "R2"; // fixed destination, full rate
      g_act[1] = 1; g_dest[1] = 2; p_valid = 100; p_ready = 100;
      run(40);
      cur_req = "R3"; // long packets, cut-through
      quiet(); g_act[2] = 1; g_dest[2] = 0; len_min = 6; len_max = 8;
      run(60);
      cur_req = "R4"; // body data bits random, routing must not follow them
      quiet(); g_act[3] = 1; len_min = 2; len_max = 5; p_valid = 60;
      run(80);
      cur_req = "R7"; // two heads race for output 1
      quiet(); g_act[0] = 1; g_dest[0] = 1; g_act[3] = 1; g_dest[3] = 1; p_valid = 100;
      run(120);
      cur_req = "R5"; // all inputs aim at output 0
      quiet(); for (int i = 0; i < P; i++) begin g_act[i] = 1; g_dest[i] = 0; end
      p_ready = 50;
      run(200);
      cur_req = "R6"; // waiting head behind a stalled tail
      quiet(); g_act[0] = 1; g_dest[0] = 3; g_act[1] = 1; g_dest[1] = 3; len_min = 2; len_max = 2;
      p_ready = 30;
      run(200);
      cur_req = "R8"; // heavy back-pressure
      quiet(); for (int i = 0; i < P; i++) g_act[i] = 1;
      len_min = 2; len_max = 5; p_valid = 70; p_ready = 40;
      run(300);
      cur_req = "R9"; // stray body flits on unbound inputs
      quiet(); p_ready = 100;
      run(30);
      g_junk[2] = 1; g_junk[0] = 1;
      run(20);
      cur_req = "R10"; // concurrent traffic on every output
      quiet(); for (int i = 0; i < P; i++) g_act[i] = 1;
      p_valid = 80; p_ready = 70;
      run(3000);
      quiet(); p_ready = 100;
      run(40);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule